// File: doc/BRIEF.md
# Serial Receive Queue with Per-Character Status

This block is the receive half of an asynchronous serial port. It oversamples the incoming line 16 times per bit and confirms a start bit at its midpoint. It then collects 5 to 8 data bits, least significant first, plus an optional parity bit and one stop bit. Each finished character goes into a 16-entry queue together with three error flags.

Software, or a bus wrapper around the block, reads the oldest entry from a single word and pops it with a one-cycle strobe. Three status conditions feed one interrupt line, and each has its own enable. The first is a dropped character. The second is a fill level at or above a programmable threshold. The third is a queue that has held data, untouched, for a programmable number of character times. A clear strobe discards everything queued.

Top module: `serial_rx_queue`

## Requirements
- R1: Frame length code `len_code` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received least significant bit first and appears right-aligned in `rd_word[7:0]`, with unused upper bits zero.
- R2: With `par_en` high, one parity bit follows the data. The parity is even when `par_odd` is 0 and odd when it is 1. A mismatch sets `rd_word[9]`, and the data is still stored.
- R3: A stop bit sampled low on a frame that is not a break sets `rd_word[8]`, and the data is still stored.
- R4: A line held low from the start bit through the stop bit is a break. It is stored as exactly one entry with `rd_word[10]` set, bits [9:0] zero. No further entry is made until the line returns high.
- R5: `rd_word` shows the oldest entry as {valid at bit 11, break at 10, parity error at 9, framing error at 8, data at [7:0]}. It is all zero when the queue is empty. A one-cycle `rd_pop` removes that entry, and entries leave in arrival order.
- R6: The queue holds 16 entries. A character that arrives when the queue is full is dropped and sets `st_ovr`. `st_ovr` stays set until an entry is popped or the queue is cleared.
- R7: `st_thr` is high exactly when the number of stored entries is at or above `thresh`.
- R8: A character time is (2 + data bits + parity bits) bit times. `st_tmo` rises once the queue has stayed non-empty for `tmo_chars` character times with no push or pop. A push or pop restarts the count. `st_tmo` is low while the queue is empty or `tmo_chars` is 0.
- R9: `irq` is the OR of `st_ovr & mask_ovr`, `st_thr & mask_thr` and `st_tmo & mask_tmo`.
- R10: A `fifo_clr` pulse empties the queue and clears `st_ovr`.
- R11: While `rx_en` is low, no character is received.
- R12: After reset the queue is empty, `rd_word` is zero and all status outputs and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | 16 | Clock cycles per oversample tick, minus one |
| len_code | input | 2 | Data bits code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| thresh | input | 5 | Fill threshold for `st_thr` |
| tmo_chars | input | 4 | Idle timeout in character times |
| mask_ovr | input | 1 | Enables overrun onto `irq` |
| mask_thr | input | 1 | Enables threshold onto `irq` |
| mask_tmo | input | 1 | Enables timeout onto `irq` |
| fifo_clr | input | 1 | Empties the queue |
| rd_pop | input | 1 | Removes the oldest entry |
| rd_word | output | 12 | Oldest entry with flags |
| not_empty | output | 1 | Queue holds at least one entry |
| st_ovr | output | 1 | Character dropped on full queue |
| st_thr | output | 1 | Fill level at or above threshold |
| st_tmo | output | 1 | Queue idle too long |
| irq | output | 1 | Masked OR of the three conditions |

## Verification
The hardest state to reach from the ports is a full queue meeting a seventeenth character. The bench sends sixteen frames back to back without popping, then sends one more. Only after that does it check the sticky overrun flag, the unchanged contents and their order. The timeout is just as narrow: the bench pops one of two stored entries at a known cycle and samples `st_tmo` on both sides of the computed two-character window.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  parameter int DIVW  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int OW   = $clog2(OSR),
  localparam int TW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            rxd,
  input  logic [DIVW-1:0] baud_div,
  input  logic [1:0]      len_code,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic [CW-1:0]   thresh,
  input  logic [3:0]      tmo_chars,
  input  logic            mask_ovr,
  input  logic            mask_thr,
  input  logic            mask_tmo,
  input  logic            fifo_clr,
  input  logic            rd_pop,
  output logic [11:0]     rd_word,
  output logic            not_empty,
  output logic            st_ovr,
  output logic            st_thr,
  output logic            st_tmo,
  output logic            irq
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} rx_st_t;

  logic [1:0]      rx_sync;
  logic            rx_s;
  logic [DIVW-1:0] div_cnt;
  logic            tick;
  rx_st_t          st;
  logic [OW-1:0]   os_cnt;
  logic [3:0]      idx;
  logic [7:0]      sh;
  logic            par_acc, all_low;
  logic            push_q;
  logic [10:0]     push_word;

  logic [10:0]     mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic            full, do_pop, do_push;
  logic [TW-1:0]   tmo_cnt, tmo_lim;

  wire [3:0] nbits    = 4'd5 + {2'b00, len_code};
  wire [3:0] stop_idx = nbits + {3'b000, par_en};
  wire [3:0] fbits    = stop_idx + 4'd2;
  wire [7:0] rx_byte  = sh >> (2'd3 - len_code);
  wire       brk_now  = all_low & ~rx_s;

  assign rx_s = rx_sync[1];
  assign tick = (div_cnt == baud_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync <= 2'b11;
      div_cnt <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      os_cnt    <= '0;
      idx       <= '0;
      sh        <= '0;
      par_acc   <= 1'b0;
      all_low   <= 1'b0;
      push_q    <= 1'b0;
      push_word <= '0;
    end else begin
      push_q <= 1'b0;
      if (!rx_en) st <= S_IDLE;
      else if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; os_cnt <= '0; end
          S_START:
            if (os_cnt == OW'(OSR/2 - 1)) begin
              if (!rx_s) begin
                st <= S_BITS; os_cnt <= '0; idx <= '0;
                par_acc <= 1'b0; all_low <= 1'b1;
              end else st <= S_IDLE;
            end else os_cnt <= os_cnt + 1'b1;
          S_BITS:
            if (os_cnt == OW'(OSR - 1)) begin
              os_cnt  <= '0;
              idx     <= idx + 1'b1;
              all_low <= all_low & ~rx_s;
              if (idx < nbits) begin
                sh <= {rx_s, sh[7:1]};
                par_acc <= par_acc ^ rx_s;
              end else if (idx != stop_idx) begin
                par_acc <= par_acc ^ rx_s;
              end else begin
                push_q    <= 1'b1;
                push_word <= brk_now ? 11'h400
                           : {1'b0, par_en & (par_acc != par_odd), ~rx_s, rx_byte};
                st        <= rx_s ? S_IDLE : S_HOLD;
              end
            end else os_cnt <= os_cnt + 1'b1;
          S_HOLD: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign do_pop    = rd_pop & not_empty;
  assign do_push   = push_q & (~full | do_pop);

  always_ff @(posedge clk)
    if (do_push && !fifo_clr) mem[wr_ptr] <= push_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; st_ovr <= 1'b0;
    end else if (fifo_clr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; st_ovr <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push_q && !do_push) st_ovr <= 1'b1;
      else if (do_pop)        st_ovr <= 1'b0;
    end

  assign tmo_lim = TW'(tmo_chars) * TW'(fbits) * TW'(OSR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (fifo_clr || do_push || do_pop || !not_empty) tmo_cnt <= '0;
    else if (tick && tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;

  assign st_tmo  = not_empty && (tmo_chars != '0) && (tmo_cnt >= tmo_lim);
  assign st_thr  = (count >= thresh);
  assign rd_word = not_empty ? {1'b1, mem[rd_ptr]} : 12'h000;
  assign irq     = (st_ovr & mask_ovr) | (st_thr & mask_thr) | (st_tmo & mask_tmo);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r6_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    push_q && full && !rd_pop && !fifo_clr |=> st_ovr && full);

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !not_empty && !st_ovr);

  a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && not_empty && !push_q && !fifo_clr |=> count == $past(count) - 1'b1);

  a_r8_restart_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && !fifo_clr && count > CW'(1) && tmo_chars != '0 |=> !st_tmo);

endmodule

// File: tb/serial_rx_queue_bench.sv
`timescale 1ns/1ps
module serial_rx_queue_bench;
  localparam int BT = 32;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rxd = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic [1:0] len_code = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic [4:0] thresh = 5'd8;
  logic [3:0] tmo_chars = 4'd0;
  logic mask_ovr = 1'b0, mask_thr = 1'b0, mask_tmo = 1'b0;
  logic fifo_clr = 1'b0, rd_pop = 1'b0;
  logic [11:0] rd_word;
  logic not_empty, st_ovr, st_thr, st_tmo, irq;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  serial_rx_queue u_serial_rx_queue (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .baud_div(baud_div),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd), .thresh(thresh),
    .tmo_chars(tmo_chars), .mask_ovr(mask_ovr), .mask_thr(mask_thr),
    .mask_tmo(mask_tmo), .fifo_clr(fifo_clr), .rd_pop(rd_pop),
    .rd_word(rd_word), .not_empty(not_empty), .st_ovr(st_ovr),
    .st_thr(st_thr), .st_tmo(st_tmo), .irq(irq));

  // {len[25:24], pen, podd, bad_par, bad_stop, data[19:12], expected word[11:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 12'h8A5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFB, 12'h81B},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2C, 12'h82C},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 12'h855},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 12'h80F},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 12'hA3C},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 12'h981},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7E, 12'hA7E}
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bits(input int n);
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] len, input logic pen, input logic podd,
                      input logic bpar, input logic bstop, input logic [7:0] d);
    logic [7:0] m;
    m = 8'hFF >> (2'd3 - len);
    rxd = 1'b0; bits(1);
    for (int i = 0; i < 5 + int'(len); i++) begin rxd = d[i]; bits(1); end
    if (pen) begin rxd = (^(d & m)) ^ podd ^ bpar; bits(1); end
    rxd = ~bstop; bits(1);
    rxd = 1'b1; bits(2);
  endtask

  task automatic pop();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 word", rd_word, 12'h000);
    chk("R12 status", {7'd0, not_empty, st_ovr, st_thr, st_tmo, irq}, 12'h000);

    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h33);
    chk("R11 disabled", {11'd0, not_empty}, 12'h000);
    rx_en = 1'b1;

    for (int v = 0; v < 8; v++) begin
      len_code = VEC[v][25:24]; par_en = VEC[v][23]; par_odd = VEC[v][22];
      send(VEC[v][25:24], VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20], VEC[v][19:12]);
      chk("R1 R2 R3 R5 vector", rd_word, VEC[v][11:0]);
      pop();
      chk("R5 empty after pop", rd_word, 12'h000);
    end

    len_code = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    rxd = 1'b0; bits(13); rxd = 1'b1; bits(2);
    chk("R4 break entry", rd_word, 12'hC00);
    pop();
    chk("R4 single entry", rd_word, 12'h000);

    thresh = 5'd8;
    for (int i = 0; i < 17; i++) begin
      send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10 + 8'(i));
      if (i == 6)  chk("R7 below thresh", {11'd0, st_thr}, 12'h000);
      if (i == 7)  chk("R7 at thresh", {11'd0, st_thr}, 12'h001);
      if (i == 15) chk("R6 full no ovr", {11'd0, st_ovr}, 12'h000);
    end
    chk("R6 ovr set", {11'd0, st_ovr}, 12'h001);
    chk("R9 all masked", {11'd0, irq}, 12'h000);
    mask_ovr = 1'b1; @(negedge clk);
    chk("R9 ovr enabled", {11'd0, irq}, 12'h001);
    mask_ovr = 1'b0; mask_thr = 1'b1; @(negedge clk);
    chk("R9 thr enabled", {11'd0, irq}, 12'h001);
    mask_thr = 1'b0;
    chk("R6 head kept", rd_word, 12'h810);
    pop();
    chk("R6 ovr cleared by pop", {11'd0, st_ovr}, 12'h000);
    for (int i = 1; i < 16; i++) begin
      chk("R5 order", rd_word, 12'h810 + 12'(i));
      pop();
    end
    chk("R6 dropped char absent", {11'd0, not_empty}, 12'h000);

    thresh = 5'd2;
    for (int i = 0; i < 3; i++) send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40);
    chk("R7 filled", {11'd0, st_thr}, 12'h001);
    @(negedge clk) fifo_clr = 1'b1;
    @(negedge clk) fifo_clr = 1'b0;
    chk("R10 cleared word", rd_word, 12'h000);
    chk("R10 cleared flags", {10'd0, not_empty, st_thr}, 12'h000);

    tmo_chars = 4'd2; mask_tmo = 1'b1;
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h61);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h62);
    pop();
    repeat (600) @(negedge clk);
    chk("R8 before window", {11'd0, st_tmo}, 12'h000);
    repeat (80) @(negedge clk);
    chk("R8 after window", {11'd0, st_tmo}, 12'h001);
    chk("R9 tmo enabled", {11'd0, irq}, 12'h001);
    chk("R8 entry intact", rd_word, 12'h862);
    pop();
    repeat (1000) @(negedge clk);
    chk("R8 empty no tmo", {11'd0, st_tmo}, 12'h000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule